// File: doc/BRIEF.md
# Frame-Synchronous Serial Port Controller

This block is a full-duplex serial port. It shifts 16-bit words out on a transmit line and in from a receive line. An external master supplies the bit clock and the frame-sync pulse, and each frame carries one word in each direction. Software (or a DMA engine) reaches the port through a small register bus:

- It writes words into an 8-entry transmit FIFO.
- It reads received words from an 8-entry receive FIFO.
- It sets the enable bits and the two watermark thresholds.
- It watches the status flags.

The port has two request outputs. `tx_req` says the transmit FIFO has room to refill. `rx_req` says the receive FIFO has words to drain.

Enable writes are only requests. The port latches them into its active state at the next frame boundary, so a frame is never cut part way. The two soft-reset bits act in the same cycle and clear themselves. All logic runs on the system clock `clk`. The bit clock `sck` is sampled once per clock, and its edges are found by comparing the sampled value with the live value. The bit clock must therefore stay at least three system clocks in each phase.

Each direction has a small state machine:

- Transmit machine: `TX_IDLE` holds the line at 1. The transition *frame-start-enabled* moves it to `TX_SHIFT`, which drives one bit on each bit-clock falling edge. The transition *last-bit* moves it to `TX_TAIL`. `TX_TAIL` returns to `TX_IDLE` on the next falling edge (*line-release*). A frame start with the enable clear, or a transmit reset, goes straight to `TX_IDLE` (*abort*).
- Receive machine: `RX_IDLE` moves to `RX_SHIFT` on *frame-start-enabled*. `RX_SHIFT` samples 16 rising edges and returns to `RX_IDLE` on *word-complete*, pushing the word. A receive reset, or a frame start with the enable clear, goes to `RX_IDLE` (*abort*).

Top module: `fsync_serial_port`

## Requirements
- R1: Register map, selected by `addr`. 0 is control. 1 is transmit data (write pushes). 2 is receive data (read returns the FIFO head and pops it). 3 is watermarks. 4 is status. Control bits:
  - bit0: transmit enable request.
  - bit1: receive enable request.
  - bit2: transmit reset. It acts on write, self-clears and always reads 0.
  - bit3: receive reset. It acts on write, self-clears and always reads 0.
  - bit4: transmit active (read-only).
  - bit5: receive active (read-only).
- R2: The active transmit and receive enables change only at a frame start, or through their reset. A frame start is a bit-clock rising edge where `fsync` is 1 and was 0 at the previous rising edge. At a frame start each active enable takes the value of its request bit.
- R3: Whenever transmission is not active, `txd` is 1.
- R4: Transmit timing: the word goes out MSB first, one bit per bit-clock falling edge, starting at the first falling edge after the frame start. `txd` returns to 1 at the 17th falling edge. Receive timing: the receiver samples `rxd` on the 16 rising edges that follow the frame start, MSB first.
- R5: Both FIFOs hold 8 words and preserve order. Status bit0 means the transmit FIFO is not full. Status bit1 means the transmit FIFO is empty. Status bit2 means the receive FIFO is not empty. Reset status reads 0x0003.
- R6: `tx_req` is 1 exactly when transmit is active and the free transmit entries are at least the transmit watermark. The transmit watermark is in watermark-register bits [3:0], reset value 4.
- R7: `rx_req` is 1 exactly when receive is active, the receive FIFO is not empty, and its count is at least the receive watermark. The receive watermark is in watermark-register bits [11:8], reset value 1.
- R8: If transmit is active at a frame start and the transmit FIFO is empty, the frame sends all ones and sets sticky status bit3 (underrun).
- R9: A write to a full transmit FIFO is dropped and sets sticky status bit4. A received word that finds the receive FIFO full is dropped and sets sticky status bit5.
- R10: A transmit reset acts in the same cycle. It forces `txd` to 1 and empties the transmit FIFO. It clears the shift register, the transmit enable request, transmit active, and status bits 3 and 4.
- R11: A receive reset acts in the same cycle. It empties the receive FIFO and clears the receive enable request, receive active and status bit5.
- R12: Writing 1 to status bits 3, 4 or 5 clears that sticky flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Bit clock from the external master |
| fsync | input | 1 | Frame-sync from the external master |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data, idles at 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops at address 2) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational |
| tx_req | output | 1 | Transmit FIFO refill request |
| rx_req | output | 1 | Receive FIFO drain request |

## Verification
Corrupted transmit state shows on `txd` within one bit period: a line that is 0 while idle, a bit that is shifted late, or a word sent out of order. A wrong receive counter or FIFO pointer shows on the next read of the receive data register, one frame after the faulty push. An enable that is latched at the wrong moment shows in the control read-back and in the request outputs before the next frame ends. A soft reset that misses part of its state leaves a status bit or a stale word visible on the very next register read.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam int unsigned DEF_WORD_W = 16;
    localparam int unsigned DEF_DEPTH  = 8;

    typedef enum logic [2:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_TXD   = 3'd1,
        ADDR_RXD   = 3'd2,
        ADDR_WMARK = 3'd3,
        ADDR_STAT  = 3'd4
    } reg_addr_e;

    // control register bit positions
    localparam int unsigned CB_TXEN  = 0;
    localparam int unsigned CB_RXEN  = 1;
    localparam int unsigned CB_TXRST = 2;
    localparam int unsigned CB_RXRST = 3;
    localparam int unsigned CB_TXACT = 4;
    localparam int unsigned CB_RXACT = 5;

    // status register bit positions
    localparam int unsigned SB_TXNF  = 0;
    localparam int unsigned SB_TXEMP = 1;
    localparam int unsigned SB_RXNE  = 2;
    localparam int unsigned SB_UNF   = 3;
    localparam int unsigned SB_TXOVF = 4;
    localparam int unsigned SB_RXOVF = 5;

    // watermark field offsets
    localparam int unsigned WM_TX_LSB = 0;
    localparam int unsigned WM_RX_LSB = 8;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_TAIL  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

endpackage

// File: rtl/fsp_fifo.sv
module fsp_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // R5
    fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R9
    fifo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

    // R5
    fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);

endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
    import fsp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         en_req,
    input  logic         frame_start,
    input  logic         sck_fall,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_word,
    output logic         fifo_pop,
    output logic         underrun_evt,
    output logic         active,
    output logic         txd
);
    localparam int unsigned CNTW = $clog2(W);

    tx_state_e     state_q, state_d;
    logic [W-1:0]  sh_q, sh_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic          act_q, act_d;
    logic          txd_q, txd_d;

    always_comb begin
        state_d      = state_q;
        sh_d         = sh_q;
        cnt_d        = cnt_q;
        act_d        = act_q;
        txd_d        = txd_q;
        fifo_pop     = 1'b0;
        underrun_evt = 1'b0;
        if (soft_rst) begin
            state_d = TX_IDLE;
            sh_d    = '0;
            cnt_d   = '0;
            act_d   = 1'b0;
            txd_d   = 1'b1;
        end else if (frame_start) begin
            act_d = en_req;
            cnt_d = '0;
            if (en_req) begin
                state_d = TX_SHIFT;
                if (fifo_empty) begin
                    sh_d         = '1;
                    underrun_evt = 1'b1;
                end else begin
                    sh_d     = fifo_word;
                    fifo_pop = 1'b1;
                end
            end else begin
                state_d = TX_IDLE;
                txd_d   = 1'b1;
            end
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    txd_d = 1'b1;
                end
                TX_SHIFT: begin
                    if (sck_fall) begin
                        txd_d = sh_q[W-1];
                        sh_d  = {sh_q[W-2:0], 1'b0};
                        if (cnt_q == CNTW'(W - 1)) begin
                            state_d = TX_TAIL;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TX_TAIL: begin
                    if (sck_fall) begin
                        txd_d   = 1'b1;
                        state_d = TX_IDLE;
                    end
                end
                default: begin
                    state_d = TX_IDLE;
                    txd_d   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            act_q   <= 1'b0;
            txd_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            txd_q   <= txd_d;
        end
    end

    assign active = act_q;
    assign txd    = txd_q;

    // R3
    tx_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> txd_q);

    // R2
    tx_enable_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> ($past(frame_start) || $past(soft_rst)));

    // R8
    tx_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
    import fsp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         en_req,
    input  logic         frame_start,
    input  logic         sck_rise,
    input  logic         rxd,
    output logic         push,
    output logic [W-1:0] word,
    output logic         active
);
    localparam int unsigned CNTW = $clog2(W);

    rx_state_e       state_q, state_d;
    logic [W-1:0]    sh_q, sh_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            act_q, act_d;

    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        push    = 1'b0;
        if (soft_rst) begin
            state_d = RX_IDLE;
            sh_d    = '0;
            cnt_d   = '0;
            act_d   = 1'b0;
        end else if (frame_start) begin
            act_d   = en_req;
            cnt_d   = '0;
            state_d = en_req ? RX_SHIFT : RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    cnt_d = '0;
                end
                RX_SHIFT: begin
                    if (sck_rise) begin
                        sh_d = {sh_q[W-2:0], rxd};
                        if (cnt_q == CNTW'(W - 1)) begin
                            push    = 1'b1;
                            state_d = RX_IDLE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    assign word   = {sh_q[W-2:0], rxd};
    assign active = act_q;

    // R4
    rx_push_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (sck_rise && act_q && !frame_start));

    // R2
    rx_enable_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> ($past(frame_start) || $past(soft_rst)));

endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port
    import fsp_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              fsync,
    input  logic              rxd,
    output logic              txd,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              tx_req,
    output logic              rx_req
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    reg_addr_e a_e;
    logic sck_q, fs_q;
    logic sck_rise, sck_fall, frame_start;
    logic wr_ctrl, wr_txd, wr_wm, wr_stat, rd_rxd;
    logic tx_rst, rx_rst;
    logic tx_en_req, rx_en_req;
    logic [CW-1:0] tx_wm, rx_wm;
    logic tx_unf, tx_ovf, rx_ovf;

    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]     tx_count, rx_count;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_pop, tx_unf_evt, tx_act, rx_push, rx_act;

    // bit-clock edge and frame detection
    assign sck_rise    = sck && !sck_q;
    assign sck_fall    = !sck && sck_q;
    assign frame_start = sck_rise && fsync && !fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            fs_q  <= 1'b0;
        end else begin
            sck_q <= sck;
            if (sck_rise) fs_q <= fsync;
        end
    end

    // register decode
    assign a_e     = reg_addr_e'(addr);
    assign wr_ctrl = wr_en && (a_e == ADDR_CTRL);
    assign wr_txd  = wr_en && (a_e == ADDR_TXD);
    assign wr_wm   = wr_en && (a_e == ADDR_WMARK);
    assign wr_stat = wr_en && (a_e == ADDR_STAT);
    assign rd_rxd  = rd_en && (a_e == ADDR_RXD);
    assign tx_rst  = wr_ctrl && wdata[CB_TXRST];
    assign rx_rst  = wr_ctrl && wdata[CB_RXRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_req <= 1'b0;
            rx_en_req <= 1'b0;
            tx_wm     <= CW'(4);
            rx_wm     <= CW'(1);
        end else begin
            if (wr_ctrl) begin
                tx_en_req <= wdata[CB_TXEN] && !wdata[CB_TXRST];
                rx_en_req <= wdata[CB_RXEN] && !wdata[CB_RXRST];
            end
            if (wr_wm) begin
                tx_wm <= wdata[WM_TX_LSB +: CW];
                rx_wm <= wdata[WM_RX_LSB +: CW];
            end
        end
    end

    // sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_unf <= 1'b0;
            tx_ovf <= 1'b0;
            rx_ovf <= 1'b0;
        end else begin
            if (tx_rst) begin
                tx_unf <= 1'b0;
                tx_ovf <= 1'b0;
            end else begin
                if (wr_stat && wdata[SB_UNF])   tx_unf <= 1'b0;
                if (tx_unf_evt)                 tx_unf <= 1'b1;
                if (wr_stat && wdata[SB_TXOVF]) tx_ovf <= 1'b0;
                if (wr_txd && tx_full)          tx_ovf <= 1'b1;
            end
            if (rx_rst) begin
                rx_ovf <= 1'b0;
            end else begin
                if (wr_stat && wdata[SB_RXOVF]) rx_ovf <= 1'b0;
                if (rx_push && rx_full)         rx_ovf <= 1'b1;
            end
        end
    end

    fsp_fifo #(.W(WORD_W), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_rst),
        .push  (wr_txd),
        .pop   (tx_pop),
        .din   (wdata),
        .dout  (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    fsp_fifo #(.W(WORD_W), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_rst),
        .push  (rx_push),
        .pop   (rd_rxd),
        .din   (rx_word),
        .dout  (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    fsp_tx #(.W(WORD_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (tx_rst),
        .en_req       (tx_en_req),
        .frame_start  (frame_start),
        .sck_fall     (sck_fall),
        .fifo_empty   (tx_empty),
        .fifo_word    (tx_head),
        .fifo_pop     (tx_pop),
        .underrun_evt (tx_unf_evt),
        .active       (tx_act),
        .txd          (txd)
    );

    fsp_rx #(.W(WORD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (rx_rst),
        .en_req      (rx_en_req),
        .frame_start (frame_start),
        .sck_rise    (sck_rise),
        .rxd         (rxd),
        .push        (rx_push),
        .word        (rx_word),
        .active      (rx_act)
    );

    // transfer requests
    assign tx_req = tx_act && ((CW'(DEPTH) - tx_count) >= tx_wm);
    assign rx_req = rx_act && !rx_empty && (rx_count >= rx_wm);

    // read mux
    always_comb begin
        rdata = '0;
        case (a_e)
            ADDR_CTRL: begin
                rdata[CB_TXEN]  = tx_en_req;
                rdata[CB_RXEN]  = rx_en_req;
                rdata[CB_TXACT] = tx_act;
                rdata[CB_RXACT] = rx_act;
            end
            ADDR_RXD:   rdata = rx_head;
            ADDR_WMARK: begin
                rdata[WM_TX_LSB +: CW] = tx_wm;
                rdata[WM_RX_LSB +: CW] = rx_wm;
            end
            ADDR_STAT: begin
                rdata[SB_TXNF]  = !tx_full;
                rdata[SB_TXEMP] = tx_empty;
                rdata[SB_RXNE]  = !rx_empty;
                rdata[SB_UNF]   = tx_unf;
                rdata[SB_TXOVF] = tx_ovf;
                rdata[SB_RXOVF] = rx_ovf;
            end
            default: rdata = '0;
        endcase
    end

    // R10
    tx_soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (tx_empty && !tx_act && txd && !tx_unf && !tx_ovf && !tx_req));

    // R11
    rx_soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (rx_empty && !rx_act && !rx_ovf && !rx_req));

    // R7
    rx_req_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |-> (rx_count != '0));

    // R6
    tx_req_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_wm != '0) |-> !tx_full);

endmodule

// File: tb/fsync_serial_port_tb.sv
module fsync_serial_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        fsync = 1'b0;
    logic        rxd = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        txd, tx_req, rx_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2, A_WM = 3'd3, A_STAT = 3'd4;

    // {transmit word, receive word}
    localparam logic [31:0] VEC [0:5] = '{
        32'hA5C3_1234, 32'h8001_FFFE, 32'h0000_8000,
        32'hFFFF_0001, 32'h6B2D_C0DE, 32'h7FFE_5AA5
    };

    always #5 clk = ~clk;

    fsync_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .fsync(fsync), .rxd(rxd), .txd(txd),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .tx_req(tx_req), .rx_req(rx_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // one frame: bit period 0 carries fsync, periods 1..16 carry data, 3 idle periods
    task automatic run_frame(input logic [15:0] rxw, output logic [15:0] txw);
        txw = 16'h0;
        for (int b = 0; b < 20; b++) begin
            @(negedge clk);
            sck = 1'b0;
            fsync = (b == 0);
            rxd = (b >= 1 && b <= 16) ? rxw[16-b] : 1'b1;
            repeat (3) @(negedge clk);
            @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
            if (b >= 1 && b <= 16) txw[16-b] = txd;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, cap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R3 idle txd", {31'b0, txd}, 32'h1);
        chk("R6 tx_req at reset", {31'b0, tx_req}, 32'h0);
        chk("R7 rx_req at reset", {31'b0, rx_req}, 32'h0);
        bus_read(A_CTRL, rd);  chk("R1 ctrl reset", {16'b0, rd}, 32'h0000);
        bus_read(A_STAT, rd);  chk("R5 status reset", {16'b0, rd}, 32'h0003);
        bus_read(A_WM, rd);    chk("R6 R7 watermark reset", {16'b0, rd}, 32'h0104);

        // arm: tx wm 8, rx wm 1; enable requested but not active until frame
        bus_write(A_WM, 16'h0108);
        bus_write(A_TXD, VEC[0][31:16]);
        bus_write(A_CTRL, 16'h0003);
        bus_read(A_CTRL, rd);  chk("R2 enable deferred", {16'b0, rd}, 32'h0003);
        chk("R6 no request before active", {31'b0, tx_req}, 32'h0);
        chk("R3 line high before active", {31'b0, txd}, 32'h1);

        // table walk
        for (int i = 0; i < 6; i++) begin
            if (i > 0) bus_write(A_TXD, VEC[i][31:16]);
            run_frame(VEC[i][15:0], cap);
            chk("R4 transmitted word", {16'b0, cap}, {16'b0, VEC[i][31:16]});
            if (i == 0) begin
                bus_read(A_CTRL, rd);
                chk("R2 enable active after frame", {16'b0, rd}, 32'h0033);
            end
            chk("R6 tx_req when empty", {31'b0, tx_req}, 32'h1);
            chk("R7 rx_req with one word", {31'b0, rx_req}, 32'h1);
            bus_read(A_RXD, rd);
            chk("R4 received word", {16'b0, rd}, {16'b0, VEC[i][15:0]});
            chk("R7 rx_req after drain", {31'b0, rx_req}, 32'h0);
        end

        // ordering and watermarks
        bus_write(A_WM, 16'h0308);
        bus_write(A_TXD, 16'h1111);
        bus_write(A_TXD, 16'h2222);
        bus_write(A_TXD, 16'h3333);
        chk("R6 below watermark", {31'b0, tx_req}, 32'h0);
        run_frame(16'hAAAA, cap); chk("R5 order 1", {16'b0, cap}, 32'h1111);
        run_frame(16'h5555, cap); chk("R5 order 2", {16'b0, cap}, 32'h2222);
        chk("R7 two words below wm 3", {31'b0, rx_req}, 32'h0);
        run_frame(16'h0F0F, cap); chk("R5 order 3", {16'b0, cap}, 32'h3333);
        chk("R7 three words reach wm 3", {31'b0, rx_req}, 32'h1);
        bus_read(A_RXD, rd); chk("R5 rx order 1", {16'b0, rd}, 32'hAAAA);
        bus_read(A_RXD, rd); chk("R5 rx order 2", {16'b0, rd}, 32'h5555);
        bus_read(A_RXD, rd); chk("R5 rx order 3", {16'b0, rd}, 32'h0F0F);
        bus_write(A_WM, 16'h0108);

        // underrun
        run_frame(16'h2468, cap);
        chk("R8 underrun sends ones", {16'b0, cap}, 32'hFFFF);
        bus_read(A_STAT, rd); chk("R8 underrun flag", {31'b0, rd[3]}, 32'h1);
        bus_read(A_RXD, rd);  chk("R4 rx during underrun", {16'b0, rd}, 32'h2468);
        bus_write(A_STAT, 16'h0008);
        bus_read(A_STAT, rd); chk("R12 underrun cleared", {31'b0, rd[3]}, 32'h0);

        // transmit overflow
        for (int k = 0; k < 9; k++) bus_write(A_TXD, 16'h0100 + 16'(k));
        bus_read(A_STAT, rd); chk("R9 tx full and overflow", {16'b0, rd & 16'h0013}, 32'h0010);
        run_frame(16'h0000, cap); chk("R9 first word kept", {16'b0, cap}, 32'h0100);
        bus_read(A_RXD, rd);
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, rd); chk("R12 zero write keeps flag", {31'b0, rd[4]}, 32'h1);

        // transmit reset
        bus_write(A_CTRL, 16'h0006);
        chk("R10 line high after reset", {31'b0, txd}, 32'h1);
        bus_read(A_STAT, rd); chk("R10 tx status cleared", {16'b0, rd & 16'h001B}, 32'h0003);
        bus_read(A_CTRL, rd); chk("R10 R1 ctrl after tx reset", {16'b0, rd}, 32'h0022);
        chk("R10 no tx request", {31'b0, tx_req}, 32'h0);
        run_frame(16'h1357, cap); chk("R3 disabled sends ones", {16'b0, cap}, 32'hFFFF);
        bus_read(A_STAT, rd); chk("R8 no underrun while disabled", {31'b0, rd[3]}, 32'h0);
        bus_read(A_RXD, rd);  chk("R4 rx after tx reset", {16'b0, rd}, 32'h1357);

        // receive overflow
        for (int k = 0; k < 9; k++) run_frame(16'h0200 + 16'(k), cap);
        bus_read(A_STAT, rd); chk("R9 rx overflow flag", {31'b0, rd[5]}, 32'h1);
        bus_read(A_RXD, rd);  chk("R9 rx oldest kept", {16'b0, rd}, 32'h0200);

        // receive reset, tx enable requested in same write
        bus_write(A_CTRL, 16'h0009);
        chk("R11 rx_req cleared", {31'b0, rx_req}, 32'h0);
        bus_read(A_STAT, rd); chk("R11 rx status cleared", {16'b0, rd & 16'h0024}, 32'h0000);
        bus_read(A_CTRL, rd); chk("R11 R1 ctrl after rx reset", {16'b0, rd}, 32'h0001);
        run_frame(16'h4444, cap);
        bus_read(A_STAT, rd); chk("R11 nothing received", {31'b0, rd[2]}, 32'h0);
        chk("R8 underrun on empty enabled frame", {16'b0, cap}, 32'hFFFF);
        bus_read(A_CTRL, rd); chk("R2 tx active at frame", {16'b0, rd}, 32'h0011);

        // deferred disable
        bus_write(A_CTRL, 16'h0000);
        bus_read(A_CTRL, rd); chk("R2 disable deferred", {16'b0, rd}, 32'h0010);
        run_frame(16'h0000, cap);
        bus_read(A_CTRL, rd); chk("R2 disabled at frame", {16'b0, rd}, 32'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule